// File: doc/BRIEF.md
# Cache-Line Instruction Fetch Extractor

This block sits between an instruction cache and the decode stage of a pipelined core. It keeps the fetch program counter of one thread and issues line requests. The address of each request is the PC with its low six bits cleared, which selects a 64-byte line. When the line comes back, the block cuts 32-bit instructions out of it and sends up to `W` of them toward decode in one registered cycle. Each instruction carries its own PC, its predicted next PC and a sequence number. A per-word prediction hint (a control flag, a taken flag and a target) comes with the line and steers the next-PC chain.

Extraction begins at the word that the PC points to. It stops at the first of three limits: the end of the line, the width limit, or an instruction that is predicted taken. The taken instruction is still emitted. A halt word is also emitted and then parks the thread in a quiesced state. If the translation of the line failed, no instructions are extracted. A single filler word is sent instead, carrying the fault code, and the thread parks in a trap state. A parked thread ignores lines and request pulses until a redirect loads a new PC. No line request leaves the block while an interrupt is pending, unless the access is in physical mode.

Top module: `fx_top`

## Requirements
- R1: `fetch_go_i` in the running state (code 0) gives `req_valid_o`=1 on the next cycle, with `req_addr_o` = PC with bits [5:0] cleared. In any other state no request is made.
- R2: The first word taken from the line has index PC[5:2], which ignores PC[1:0]. Word j is `line_i[32j+31:32j]`, so the instruction bytes are little-endian.
- R3: Slots fill from slot 0 upward with no gaps. Extraction stops at word 15, at `W` slots, or after an instruction whose `hint_ctrl_i` and `hint_taken_i` bits are both 1. That instruction is emitted. `out_count_o` equals the number of valid slots.
- R4: The predicted next PC of a slot is the hint target of its word if the word is predicted taken, and the slot PC + 4 otherwise. The PC of slot k+1 equals the predicted next PC of slot k. The PC of slot 0 is the thread PC.
- R5: `out_seq_o` is the sequence number of slot 0, and slot k has `out_seq_o`+k. The counter starts at 0 after reset and advances by the number of instructions emitted, a fault filler included.
- R6: One cycle after a line is accepted, `pc_o` holds the predicted next PC of the last emitted slot and `npc_o` = `pc_o` + 4.
- R7: A line with `xlat_fault_i`=1 emits only slot 0. That slot has inst = `NOP_WORD` (0xF000_0000), PC = thread PC, next PC = PC + 4, `out_fault_o`=1 and the given fault code. The state becomes 2 (trap) and the PC is kept.
- R8: A word equal to `HALT_WORD` (0xFFFF_FFF0) is emitted as the last slot, and the state becomes 1 (quiesced).
- R9: A request is suppressed while `intr_pending_i`=1 and `phys_mode_i`=0. It is allowed when `phys_mode_i`=1.
- R10: In state 1 or 2, lines and `fetch_go_i` are ignored. No slot is valid, no request is made and the PC is held.
- R11: `redirect_i` loads the PC and sets state 0. A line in the same cycle is dropped.
- R12: After reset: PC = `RESET_PC` (0x1000), `npc_o` = 0x1004, state 0, no valid slot, no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Load a new PC and resume running |
| redirect_pc_i | input | 32 | PC loaded by a redirect |
| fetch_go_i | input | 1 | Ask for the line holding the current PC |
| intr_pending_i | input | 1 | An interrupt is pending |
| phys_mode_i | input | 1 | Access is in physical mode |
| req_valid_o | output | 1 | Line request valid |
| req_addr_o | output | 32 | Line-aligned request address |
| line_valid_i | input | 1 | A fetched line is present |
| line_i | input | 512 | Line data, word j at bits 32j+31:32j |
| xlat_fault_i | input | 1 | Translation of this line failed |
| fault_code_i | input | 8 | Fault code to carry |
| hint_ctrl_i | input | 16 | Per-word control flag |
| hint_taken_i | input | 16 | Per-word predicted-taken flag |
| hint_tgt_i | input | 512 | Per-word predicted target |
| out_valid_o | output | W | Slot valid vector |
| out_inst_o | output | 32*W | Slot instructions |
| out_pc_o | output | 32*W | Slot PCs |
| out_npc_o | output | 32*W | Slot predicted next PCs |
| out_seq_o | output | 16 | Sequence number of slot 0 |
| out_count_o | output | clog2(W+1) | Number of valid slots |
| out_fault_o | output | 1 | Slot 0 is a fault filler |
| out_fault_code_o | output | 8 | Fault code of the filler |
| state_o | output | 2 | 0 running, 1 quiesced, 2 trap |
| pc_o | output | 32 | Thread PC |
| npc_o | output | 32 | Thread PC + 4 |

## Verification
Every result is registered exactly once. Slots, count, sequence number, PC and state all appear on the first rising edge after the line or redirect is presented, and a request appears on the first edge after `fetch_go_i`. The bench drives each stimulus on a falling edge. Its behavioural model computes the expected outputs at that moment, and all outputs are compared on the next falling edge, one edge later. Quiet cycles are compared as well, so the all-zero slot vector and the held PC that should follow are checked.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int LINE_BYTES = 64;
  localparam int INST_W     = 32;
  localparam int WORDS      = LINE_BYTES / (INST_W / 8);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WIDX_W     = $clog2(WORDS);

  typedef enum logic [1:0] {
    FX_RUN     = 2'd0,
    FX_QUIESCE = 2'd1,
    FX_TRAP    = 2'd2
  } fx_state_e;
endpackage

// File: rtl/fx_req_gate.sv
module fx_req_gate
  import fx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        running,
  input  logic        intr_pending,
  input  logic        phys_mode,
  input  logic [31:0] pc,
  output logic        req_valid,
  output logic [31:0] req_addr
);
  logic hold_off;
  assign hold_off = intr_pending && !phys_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= go && running && !hold_off;
      req_addr  <= {pc[31:OFF_W], {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fx_slot_extract.sv
module fx_slot_extract
  import fx_pkg::*;
#(
  parameter int W         = 4,
  parameter logic [31:0] HALT_WORD = 32'hFFFF_FFF0,
  localparam int CNT_W    = $clog2(W + 1)
)(
  input  logic [31:0]       pc,
  input  logic [LINE_W-1:0] line,
  input  logic [WORDS-1:0]  ctrl,
  input  logic [WORDS-1:0]  taken,
  input  logic [LINE_W-1:0] tgt,
  output logic [W-1:0]      valid,
  output logic [W*32-1:0]   inst,
  output logic [W*32-1:0]   spc,
  output logic [W*32-1:0]   snpc,
  output logic [31:0]       npc_last,
  output logic              halt_hit,
  output logic [CNT_W-1:0]  cnt
);
  logic [31:0]       cur;
  logic [31:0]       nxt;
  logic [31:0]       word;
  logic              alive;
  logic              tk;
  logic [WIDX_W:0]   widx;
  int                idx;

  always_comb begin
    cur      = pc;
    alive    = 1'b1;
    valid    = '0;
    inst     = '0;
    spc      = '0;
    snpc     = '0;
    npc_last = pc;
    halt_hit = 1'b0;
    cnt      = '0;
    nxt      = '0;
    word     = '0;
    tk       = 1'b0;
    widx     = '0;
    idx      = 0;
    for (int k = 0; k < W; k++) begin
      widx = (WIDX_W + 1)'(pc[OFF_W-1:2]) + (WIDX_W + 1)'(k);
      if (alive && !widx[WIDX_W]) begin
        idx              = int'(widx[WIDX_W-1:0]);
        word             = line[idx*32 +: 32];
        tk               = ctrl[idx] && taken[idx];
        nxt              = tk ? tgt[idx*32 +: 32] : cur + 32'd4;
        valid[k]         = 1'b1;
        inst[k*32 +: 32] = word;
        spc[k*32 +: 32]  = cur;
        snpc[k*32 +: 32] = nxt;
        npc_last         = nxt;
        cnt              = cnt + CNT_W'(1);
        if (word == HALT_WORD) begin
          halt_hit = 1'b1;
          alive    = 1'b0;
        end
        if (tk) alive = 1'b0;
        cur = nxt;
      end
    end
  end
endmodule

// File: rtl/fx_top.sv
module fx_top
  import fx_pkg::*;
#(
  parameter int W                  = 4,
  parameter int SEQ_W              = 16,
  parameter int FC_W               = 8,
  parameter logic [31:0] RESET_PC  = 32'h0000_1000,
  parameter logic [31:0] HALT_WORD = 32'hFFFF_FFF0,
  parameter logic [31:0] NOP_WORD  = 32'hF000_0000,
  localparam int CNT_W             = $clog2(W + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect_i,
  input  logic [31:0]       redirect_pc_i,
  input  logic              fetch_go_i,
  input  logic              intr_pending_i,
  input  logic              phys_mode_i,
  output logic              req_valid_o,
  output logic [31:0]       req_addr_o,
  input  logic              line_valid_i,
  input  logic [511:0]      line_i,
  input  logic              xlat_fault_i,
  input  logic [FC_W-1:0]   fault_code_i,
  input  logic [15:0]       hint_ctrl_i,
  input  logic [15:0]       hint_taken_i,
  input  logic [511:0]      hint_tgt_i,
  output logic [W-1:0]      out_valid_o,
  output logic [W*32-1:0]   out_inst_o,
  output logic [W*32-1:0]   out_pc_o,
  output logic [W*32-1:0]   out_npc_o,
  output logic [SEQ_W-1:0]  out_seq_o,
  output logic [CNT_W-1:0]  out_count_o,
  output logic              out_fault_o,
  output logic [FC_W-1:0]   out_fault_code_o,
  output logic [1:0]        state_o,
  output logic [31:0]       pc_o,
  output logic [31:0]       npc_o
);
  fx_state_e         st;
  logic [31:0]       pc_q;
  logic [SEQ_W-1:0]  seq_q;

  logic [W-1:0]      x_valid;
  logic [W*32-1:0]   x_inst, x_pc, x_npc;
  logic [31:0]       x_last;
  logic              x_halt;
  logic [CNT_W-1:0]  x_cnt;
  logic              take_line;

  assign take_line = line_valid_i && !redirect_i && (st == FX_RUN);

  fx_req_gate u_req (
    .clk          (clk),
    .rst          (rst),
    .go           (fetch_go_i),
    .running      (st == FX_RUN),
    .intr_pending (intr_pending_i),
    .phys_mode    (phys_mode_i),
    .pc           (pc_q),
    .req_valid    (req_valid_o),
    .req_addr     (req_addr_o)
  );

  fx_slot_extract #(.W(W), .HALT_WORD(HALT_WORD)) u_ext (
    .pc       (pc_q),
    .line     (line_i),
    .ctrl     (hint_ctrl_i),
    .taken    (hint_taken_i),
    .tgt      (hint_tgt_i),
    .valid    (x_valid),
    .inst     (x_inst),
    .spc      (x_pc),
    .snpc     (x_npc),
    .npc_last (x_last),
    .halt_hit (x_halt),
    .cnt      (x_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= FX_RUN;
      pc_q             <= RESET_PC;
      npc_o            <= RESET_PC + 32'd4;
      seq_q            <= '0;
      out_valid_o      <= '0;
      out_inst_o       <= '0;
      out_pc_o         <= '0;
      out_npc_o        <= '0;
      out_seq_o        <= '0;
      out_count_o      <= '0;
      out_fault_o      <= 1'b0;
      out_fault_code_o <= '0;
    end else begin
      out_valid_o      <= '0;
      out_inst_o       <= '0;
      out_pc_o         <= '0;
      out_npc_o        <= '0;
      out_seq_o        <= '0;
      out_count_o      <= '0;
      out_fault_o      <= 1'b0;
      out_fault_code_o <= '0;
      if (redirect_i) begin
        st    <= FX_RUN;
        pc_q  <= redirect_pc_i;
        npc_o <= redirect_pc_i + 32'd4;
      end else if (take_line && xlat_fault_i) begin
        out_valid_o        <= W'(1);
        out_inst_o[31:0]   <= NOP_WORD;
        out_pc_o[31:0]     <= pc_q;
        out_npc_o[31:0]    <= pc_q + 32'd4;
        out_seq_o          <= seq_q;
        out_count_o        <= CNT_W'(1);
        out_fault_o        <= 1'b1;
        out_fault_code_o   <= fault_code_i;
        seq_q              <= seq_q + SEQ_W'(1);
        st                 <= FX_TRAP;
      end else if (take_line) begin
        out_valid_o <= x_valid;
        out_inst_o  <= x_inst;
        out_pc_o    <= x_pc;
        out_npc_o   <= x_npc;
        out_seq_o   <= seq_q;
        out_count_o <= x_cnt;
        seq_q       <= seq_q + SEQ_W'(x_cnt);
        pc_q        <= x_last;
        npc_o       <= x_last + 32'd4;
        if (x_halt) st <= FX_QUIESCE;
      end
    end
  end

  assign state_o = st;
  assign pc_o    = pc_q;
endmodule

// File: rtl/fx_check.sv
module fx_check #(
  parameter int W     = 4,
  localparam int CNT_W = $clog2(W + 1)
)(
  input logic             clk,
  input logic             rst,
  input logic             redirect_i,
  input logic             intr_pending_i,
  input logic             phys_mode_i,
  input logic             req_valid_o,
  input logic [31:0]      req_addr_o,
  input logic [W-1:0]     out_valid_o,
  input logic [CNT_W-1:0] out_count_o,
  input logic             out_fault_o,
  input logic [1:0]       state_o,
  input logic [31:0]      pc_o
);
  // R1: requests are line aligned
  p_req_align_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_addr_o[5:0] == 6'd0));

  // R9: pending interrupt outside physical mode blocks the next request
  p_intr_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (intr_pending_i && !phys_mode_i) |=> !req_valid_o);

  // R3: slots are contiguous from slot 0 and the count matches
  p_contig_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o & (out_valid_o + W'(1))) == '0);
  p_count_r3: assert property (@(posedge clk) disable iff (rst)
    out_count_o == CNT_W'($countones(out_valid_o)));

  // R7: a fault filler is alone
  p_fault_single_r7: assert property (@(posedge clk) disable iff (rst)
    out_fault_o |-> (out_valid_o == W'(1)));

  // R10: a parked thread emits nothing and holds its PC
  p_parked_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd0) |=> (out_valid_o == '0));
  p_parked_pc_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd0 && !redirect_i) |=> $stable(pc_o));
endmodule

bind fx_top fx_check #(.W(W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .redirect_i     (redirect_i),
  .intr_pending_i (intr_pending_i),
  .phys_mode_i    (phys_mode_i),
  .req_valid_o    (req_valid_o),
  .req_addr_o     (req_addr_o),
  .out_valid_o    (out_valid_o),
  .out_count_o    (out_count_o),
  .out_fault_o    (out_fault_o),
  .state_o        (state_o),
  .pc_o           (pc_o)
);

// File: tb/sim_fx_top.sv
`timescale 1ns/1ps
module sim_fx_top;
  localparam int W = 4;
  localparam int CW = $clog2(W + 1);
  localparam logic [31:0] HALT = 32'hFFFF_FFF0;
  localparam logic [31:0] NOP  = 32'hF000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic redirect = 0, go = 0, intr = 0, phys = 0, lv = 0, flt = 0;
  logic [31:0] rpc = '0;
  logic [7:0] fcode = '0;
  logic [511:0] line = '0, tgtv = '0;
  logic [15:0] hc = '0, ht = '0;

  logic req_v; logic [31:0] req_a;
  logic [W-1:0] ov; logic [W*32-1:0] oi, op, onp;
  logic [15:0] oseq; logic [CW-1:0] ocnt; logic ofl; logic [7:0] ofc;
  logic [1:0] st; logic [31:0] pc, npc;

  fx_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .redirect_i(redirect), .redirect_pc_i(rpc),
    .fetch_go_i(go), .intr_pending_i(intr), .phys_mode_i(phys),
    .req_valid_o(req_v), .req_addr_o(req_a), .line_valid_i(lv), .line_i(line),
    .xlat_fault_i(flt), .fault_code_i(fcode), .hint_ctrl_i(hc), .hint_taken_i(ht),
    .hint_tgt_i(tgtv), .out_valid_o(ov), .out_inst_o(oi), .out_pc_o(op),
    .out_npc_o(onp), .out_seq_o(oseq), .out_count_o(ocnt), .out_fault_o(ofl),
    .out_fault_code_o(ofc), .state_o(st), .pc_o(pc), .npc_o(npc)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // behavioural model state
  int unsigned m_pc, m_seq, m_st;
  int unsigned lw[16], tg[16];
  bit bc[16], bt[16];
  // expected outputs
  bit e_rv; int unsigned e_ra;
  bit e_v[W]; int unsigned e_i[W], e_p[W], e_n[W];
  int unsigned e_seq, e_cnt, e_fc; bit e_fl;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic build_line();
    for (int j = 0; j < 16; j++) begin
      line[j*32 +: 32] = lw[j];
      tgtv[j*32 +: 32] = tg[j];
      hc[j] = bc[j];
      ht[j] = bt[j];
    end
  endtask

  task automatic fill(input int unsigned base);
    for (int j = 0; j < 16; j++) begin
      lw[j] = base + 32'(j) * 32'h10;
      tg[j] = 32'h0;
      bc[j] = 0;
      bt[j] = 0;
    end
  endtask

  // model one clock edge from the currently driven inputs
  task automatic model();
    bit alive;
    int unsigned cur, nxt, idx, w;
    e_rv = go && (m_st == 0) && !(intr && !phys);
    e_ra = m_pc & 32'hFFFF_FFC0;
    for (int k = 0; k < W; k++) begin
      e_v[k] = 0; e_i[k] = 0; e_p[k] = 0; e_n[k] = 0;
    end
    e_seq = 0; e_cnt = 0; e_fl = 0; e_fc = 0;
    if (redirect) begin
      m_pc = rpc; m_st = 0;
    end else if (lv && m_st == 0 && flt) begin
      e_v[0] = 1; e_i[0] = NOP; e_p[0] = m_pc; e_n[0] = m_pc + 4;
      e_seq = m_seq; e_cnt = 1; e_fl = 1; e_fc = fcode;
      m_seq = (m_seq + 1) & 32'hFFFF; m_st = 2;
    end else if (lv && m_st == 0) begin
      alive = 1; cur = m_pc; e_seq = m_seq;
      for (int k = 0; k < W; k++) begin
        idx = ((m_pc >> 2) & 15) + k;
        if (alive && idx < 16) begin
          w = lw[idx];
          nxt = (bc[idx] && bt[idx]) ? tg[idx] : cur + 4;
          e_v[k] = 1; e_i[k] = w; e_p[k] = cur; e_n[k] = nxt;
          e_cnt++;
          if (w == HALT) begin alive = 0; m_st = 1; end
          if (bc[idx] && bt[idx]) alive = 0;
          cur = nxt;
        end
      end
      m_pc = cur;
      m_seq = (m_seq + e_cnt) & 32'hFFFF;
    end
  endtask

  // apply model, wait one edge, compare everything at the falling edge
  task automatic step(input string tag);
    model();
    @(negedge clk);
    chk({tag, " req_valid"}, req_v, e_rv);
    if (e_rv) chk({tag, " req_addr"}, req_a, e_ra);
    for (int k = 0; k < W; k++) begin
      chk($sformatf("%s valid[%0d]", tag, k), ov[k], e_v[k]);
      chk($sformatf("%s inst[%0d]", tag, k), oi[k*32 +: 32], e_i[k]);
      chk($sformatf("%s pc[%0d]", tag, k), op[k*32 +: 32], e_p[k]);
      chk($sformatf("%s npc[%0d]", tag, k), onp[k*32 +: 32], e_n[k]);
    end
    chk({tag, " count"}, ocnt, e_cnt);
    if (e_cnt != 0) chk({tag, " seq"}, oseq, e_seq);
    chk({tag, " fault"}, ofl, e_fl);
    chk({tag, " fault_code"}, ofc, e_fc);
    chk({tag, " state"}, st, m_st);
    chk({tag, " thread_pc"}, pc, m_pc);
    chk({tag, " thread_npc"}, npc, m_pc + 4);
    redirect = 0; go = 0; lv = 0; flt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h1000; m_seq = 0; m_st = 0;
    fill(32'hA000_0000); build_line();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12 reset state (quiet cycle after reset)
    step("R12 reset");
    // R1 request from reset PC
    go = 1; step("R1 go");
    // R11 redirect beats a same-cycle line
    redirect = 1; rpc = 32'h1234; lv = 1; step("R11 redirect wins");
    go = 1; step("R1 aligned req");
    // R2/R3 line end limit: start word 13, three words
    fill(32'hA100_0000); build_line(); lv = 1; step("R2 R3 line end");
    // R3 width limit
    redirect = 1; rpc = 32'h2000; step("R11 redirect");
    fill(32'hA200_0000); build_line(); lv = 1; step("R3 width limit");
    // R4 not-taken control at word 4, taken at word 5
    fill(32'hA300_0000); bc[4] = 1; bc[5] = 1; bt[5] = 1; tg[5] = 32'h3008;
    build_line(); lv = 1; step("R4 taken branch");
    // R4 taken flag without control flag has no effect
    fill(32'hA400_0000); bt[2] = 1; tg[2] = 32'h7777_0000; build_line(); lv = 1;
    step("R4 taken without ctrl");
    // R5 sequence continuity over a full-width line
    fill(32'hA500_0000); build_line(); lv = 1; step("R5 R6 sequence");
    // R8 halt word at start offset +1
    fill(32'hA600_0000); lw[((m_pc >> 2) & 15) + 1] = HALT; build_line(); lv = 1;
    step("R8 halt");
    // R10 parked: line and go ignored
    fill(32'hA700_0000); build_line(); lv = 1; go = 1; step("R10 quiesced ignore");
    step("R10 quiesced idle");
    // R9 interrupt gating
    redirect = 1; rpc = 32'h4006; step("R11 resume");
    intr = 1; go = 1; step("R9 blocked");
    phys = 1; go = 1; step("R9 physical allowed");
    intr = 0; phys = 0;
    // R2 low PC bits ignored for word index
    fill(32'hA800_0000); build_line(); lv = 1; step("R2 unaligned pc");
    // R7 fault filler
    fcode = 8'h5C; flt = 1; lv = 1; step("R7 fault");
    lv = 1; go = 1; step("R10 trap ignore");
    // recover and check word 0 start plus taken branch at last slot
    redirect = 1; rpc = 32'h5000; step("R11 recover");
    fill(32'hA900_0000); bc[3] = 1; bt[3] = 1; tg[3] = 32'h6040; build_line(); lv = 1;
    step("R3 R4 branch at width edge");
    fill(32'hAA00_0000); bc[0] = 1; bt[0] = 1; tg[0] = 32'h1_0000; build_line(); lv = 1;
    step("R3 taken first slot");
    step("R6 quiet");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule